// File: doc/BRIEF.md
# Multi-Mode PWM Timer Counter

This block is a 16-bit timer counter that advances once for every cycle in which its count-enable tick is high. A 4-bit waveform mode selects one of sixteen behaviours: plain free-running counting, clear-on-match counting, single-slope (fast) PWM, dual-slope phase-correct PWM, and dual-slope PWM whose compare values change only at the bottom of the ramp. Each mode fixes four things. These are where the ceiling (TOP) comes from, whether the counter ramps in one direction or two, when the double-buffered compare values take effect, and which counter event raises the overflow flag.

Software-visible state is kept to what the function needs. There are two compare registers, each with a write buffer and an active copy, and a capture register that can serve as TOP. A single PWM output follows compare channel B. Three sticky flags (overflow, match A, match B) are set by counter events and cleared by writing ones to a clear strobe. The prescaler, bus decoding and interrupt routing belong to the surrounding logic.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted and right after it, count is 0, all three flags are 0, pwmOut is 0, and both compare registers and the capture register read as 0.
- R2: In single-slope modes (0, 4, 5, 6, 7, 12, 14, 15) each tick moves count from TOP to 0 and otherwise adds 1 (wrapping 0xFFFF to 0). When tick is low, count holds.
- R3: In dual-slope modes (1, 2, 3, 8, 9, 10, 11) count rises by 1 per tick while in the up direction. A tick taken at or above TOP turns the direction down and subtracts 1. A tick taken at 0 while going down turns it up and adds 1. The direction is up after reset.
- R4: TOP is 0xFFFF in mode 0. It is 0x00FF in modes 1 and 5, 0x01FF in modes 2 and 6, and 0x03FF in modes 3 and 7. It is the active compare A value in modes 4, 9, 11 and 15, and the capture register in modes 8, 10, 12 and 14.
- R5: In modes 0, 4 and 12 a compare write changes the active value at once. In modes 1, 2, 3, 10 and 11 it is held in a buffer and copied to the active value on a tick taken at TOP. In modes 5 to 9, 14 and 15 the copy happens on a tick taken at 0. The capture register always takes a write at once.
- R6: The overflow flag sets on a tick taken at 0xFFFF in modes 0, 4 and 12, on a tick taken at TOP in modes 5, 6, 7, 14 and 15, and on a tick taken at 0 in modes 1, 2, 3, 8, 9, 10 and 11.
- R7: The match A flag sets on a tick taken while count equals the active compare A value. The match B flag does the same for compare B.
- R8: flagClr bit 0 clears the overflow flag, bit 1 the match A flag and bit 2 the match B flag, one cycle after the strobe. A set event in the same cycle wins over the clear.
- R9: In fast PWM modes (5, 6, 7, 14, 15) pwmOut falls after a tick taken at the active compare B value. Otherwise it rises after a tick taken at TOP, which starts the next ramp from 0.
- R10: In dual-slope modes pwmOut falls after a tick taken at the active compare B value while counting up, and rises after such a tick while counting down.
- R11: In modes 0, 4, 12 and 13 pwmOut is 0 from the next cycle on. Mode 13 is reserved: ticks neither move count nor set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 4 | Waveform mode select |
| wrCmpA | input | 1 | Write wrData to compare A |
| wrCmpB | input | 1 | Write wrData to compare B |
| wrCapt | input | 1 | Write wrData to the capture register |
| wrData | input | 16 | Write data for the three registers |
| flagClr | input | 3 | Write-one-to-clear: bit 0 overflow, bit 1 match A, bit 2 match B |
| count | output | 16 | Current counter value |
| pwmOut | output | 1 | PWM waveform driven by compare B |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpAFlag | output | 1 | Sticky compare A match flag |
| cmpBFlag | output | 1 | Sticky compare B match flag |

## Verification
On every cycle the assertions check several local rules. A missing tick freezes the count. The reserved mode freezes it too. The fixed 8-bit fast ramp wraps at 0x00FF, and fixed-TOP dual ramps always move by exactly one. A flag can only rise on a tick, and a clear without a tick always lowers it. The PWM output idles low in modes without a waveform. Which event loads a buffered compare value, where each mode's TOP comes from, and the exact edges of the PWM waveform depend on sequences of writes and ticks. Only the bench scenarios show these, by comparing each cycle against a model built from the mode table and by directed checks of buffered and immediate updates.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    TOP_FULL, TOP_8B, TOP_9B, TOP_10B, TOP_CMPA, TOP_CAPT
  } topSrc_t;

  typedef enum logic [1:0] { LD_NOW, LD_TOP, LD_BOTTOM } loadPt_t;
  typedef enum logic [1:0] { OV_MAX, OV_TOP, OV_BOTTOM } ovfPt_t;
  typedef enum logic [1:0] { WAVE_NONE, WAVE_FAST, WAVE_DUAL } wave_t;

  typedef struct packed {
    topSrc_t topSrc;
    logic    dual;
    loadPt_t loadPt;
    ovfPt_t  ovfPt;
    wave_t   wave;
    logic    halt;
  } modeCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
    logic loadAct;
    logic wrThrough;
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic atZero;
    logic atMax;
    logic atTop;
    logic pastTop;
    logic matchA;
    logic matchB;
  } dpStat_t;

  function automatic modeCfg_t decodeMode(input logic [3:0] m);
    modeCfg_t c;
    c = '{TOP_FULL, 1'b0, LD_NOW, OV_MAX, WAVE_NONE, 1'b0};
    case (m)
      4'd0:  c = '{TOP_FULL, 1'b0, LD_NOW,    OV_MAX,    WAVE_NONE, 1'b0};
      4'd1:  c = '{TOP_8B,   1'b1, LD_TOP,    OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd2:  c = '{TOP_9B,   1'b1, LD_TOP,    OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd3:  c = '{TOP_10B,  1'b1, LD_TOP,    OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd4:  c = '{TOP_CMPA, 1'b0, LD_NOW,    OV_MAX,    WAVE_NONE, 1'b0};
      4'd5:  c = '{TOP_8B,   1'b0, LD_BOTTOM, OV_TOP,    WAVE_FAST, 1'b0};
      4'd6:  c = '{TOP_9B,   1'b0, LD_BOTTOM, OV_TOP,    WAVE_FAST, 1'b0};
      4'd7:  c = '{TOP_10B,  1'b0, LD_BOTTOM, OV_TOP,    WAVE_FAST, 1'b0};
      4'd8:  c = '{TOP_CAPT, 1'b1, LD_BOTTOM, OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd9:  c = '{TOP_CMPA, 1'b1, LD_BOTTOM, OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd10: c = '{TOP_CAPT, 1'b1, LD_TOP,    OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd11: c = '{TOP_CMPA, 1'b1, LD_TOP,    OV_BOTTOM, WAVE_DUAL, 1'b0};
      4'd12: c = '{TOP_CAPT, 1'b0, LD_NOW,    OV_MAX,    WAVE_NONE, 1'b0};
      4'd13: c = '{TOP_FULL, 1'b0, LD_NOW,    OV_MAX,    WAVE_NONE, 1'b1};
      4'd14: c = '{TOP_CAPT, 1'b0, LD_BOTTOM, OV_TOP,    WAVE_FAST, 1'b0};
      default: c = '{TOP_CMPA, 1'b0, LD_BOTTOM, OV_TOP,  WAVE_FAST, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  topSrc_t          topSrc,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic             wrCapt,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output dpStat_t          stat
);

  localparam int CMP_N = 2;
  localparam logic [CNT_W-1:0] TOP_8  = CNT_W'((1 << 8) - 1);
  localparam logic [CNT_W-1:0] TOP_9  = CNT_W'((1 << 9) - 1);
  localparam logic [CNT_W-1:0] TOP_10 = CNT_W'((1 << 10) - 1);

  logic [CMP_N-1:0] wrCmp;
  logic [CNT_W-1:0] actAll [CMP_N];
  logic [CNT_W-1:0] captReg;
  logic [CNT_W-1:0] topVal;

  assign wrCmp = {wrCmpB, wrCmpA};

  // One buffered compare channel per register
  for (genvar ch = 0; ch < CMP_N; ch++) begin : g_cmp
    logic [CNT_W-1:0] bufVal;
    logic [CNT_W-1:0] actVal;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufVal <= '0;
        actVal <= '0;
      end else begin
        if (wrCmp[ch]) bufVal <= wrData;
        if (wrCmp[ch] && ctl.wrThrough) actVal <= wrData;
        else if (ctl.loadAct)           actVal <= bufVal;
      end
    end
    assign actAll[ch] = actVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       captReg <= '0;
    else if (wrCapt) captReg <= wrData;
  end

  always_comb begin
    case (topSrc)
      TOP_8B:   topVal = TOP_8;
      TOP_9B:   topVal = TOP_9;
      TOP_10B:  topVal = TOP_10;
      TOP_CMPA: topVal = actAll[0];
      TOP_CAPT: topVal = captReg;
      default:  topVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (ctl.clr) cnt <= '0;
    else if (ctl.inc) cnt <= cnt + 1'b1;
    else if (ctl.dec) cnt <= cnt - 1'b1;
  end

  assign stat.atZero  = (cnt == '0);
  assign stat.atMax   = &cnt;
  assign stat.atTop   = (cnt == topVal);
  assign stat.pastTop = (cnt >= topVal);
  assign stat.matchA  = (cnt == actAll[0]);
  assign stat.matchB  = (cnt == actAll[1]);

  // R2: a clear strobe always lands the counter on zero
  p_clear_lands_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (cnt == '0));

endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [3:0] mode,
  input  logic [2:0] flagClr,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output topSrc_t    topSrc,
  output logic       pwmOut,
  output logic       ovfFlag,
  output logic [1:0] cmpFlag
);

  modeCfg_t cfg;
  logic     run;
  logic     dirUp;
  logic     ovfEvt;
  logic [1:0] matchEvt;

  assign cfg    = decodeMode(mode);
  assign topSrc = cfg.topSrc;
  assign run    = tick && !cfg.halt;

  always_comb begin
    ctl = '0;
    ctl.wrThrough = (cfg.loadPt == LD_NOW);
    ctl.loadAct   = run && (((cfg.loadPt == LD_TOP) && stat.atTop) ||
                            ((cfg.loadPt == LD_BOTTOM) && stat.atZero));
    if (run) begin
      if (!cfg.dual) begin
        if (stat.atTop) ctl.clr = 1'b1;
        else            ctl.inc = 1'b1;
      end else if (dirUp) begin
        if (stat.pastTop) ctl.dec = !stat.atZero;
        else              ctl.inc = 1'b1;
      end else begin
        if (stat.atZero) ctl.inc = !stat.atTop;
        else             ctl.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirUp <= 1'b1;
    else if (run && cfg.dual) begin
      if (dirUp && stat.pastTop)     dirUp <= 1'b0;
      else if (!dirUp && stat.atZero) dirUp <= 1'b1;
    end
  end

  always_comb begin
    case (cfg.ovfPt)
      OV_TOP:    ovfEvt = run && stat.atTop;
      OV_BOTTOM: ovfEvt = run && stat.atZero;
      default:   ovfEvt = run && stat.atMax;
    endcase
  end

  assign matchEvt = {run && stat.matchB, run && stat.matchA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= '0;
    end else begin
      ovfFlag <= ovfEvt | (ovfFlag & ~flagClr[0]);
      cmpFlag <= matchEvt | (cmpFlag & ~flagClr[2:1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmOut <= 1'b0;
    else begin
      case (cfg.wave)
        WAVE_FAST: begin
          if (matchEvt[1])            pwmOut <= 1'b0;
          else if (run && stat.atTop) pwmOut <= 1'b1;
        end
        WAVE_DUAL: if (matchEvt[1]) pwmOut <= !dirUp;
        default:   pwmOut <= 1'b0;
      endcase
    end
  end

  // R6: the overflow flag only rises after a tick
  p_ovf_needs_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(tick));

  // R7: match flags only rise after a tick
  p_match_needs_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpFlag[0]) || $rose(cmpFlag[1])) |-> $past(tick));

  // R8: a clear with no tick always drops the flag
  p_clear_wins_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr[1] && !tick) |=> !cmpFlag[0]);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [3:0]       mode,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic             wrCapt,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       flagClr,
  output logic [CNT_W-1:0] count,
  output logic             pwmOut,
  output logic             ovfFlag,
  output logic             cmpAFlag,
  output logic             cmpBFlag
);

  dpCtl_t     ctl;
  dpStat_t    stat;
  topSrc_t    topSrc;
  logic [1:0] cmpFlag;

  pwm_timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .mode    (mode),
    .flagClr (flagClr),
    .stat    (stat),
    .ctl     (ctl),
    .topSrc  (topSrc),
    .pwmOut  (pwmOut),
    .ovfFlag (ovfFlag),
    .cmpFlag (cmpFlag)
  );

  pwm_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .topSrc (topSrc),
    .wrCmpA (wrCmpA),
    .wrCmpB (wrCmpB),
    .wrCapt (wrCapt),
    .wrData (wrData),
    .cnt    (count),
    .stat   (stat)
  );

  assign cmpAFlag = cmpFlag[0];
  assign cmpBFlag = cmpFlag[1];

  // R2: without a tick the count holds
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  // R4: the fixed 8-bit fast ramp wraps after 0x00FF
  p_fast8_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && mode == 4'd5 && count == CNT_W'(255)) |=> (count == '0));

  // R3: fixed-TOP dual ramps move by exactly one per tick
  p_dual_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (mode == 4'd1 || mode == 4'd2 || mode == 4'd3)) |=>
      ((count == $past(count) + CNT_W'(1)) || (count == $past(count) - CNT_W'(1))));

  // R11: reserved mode freezes the count
  p_reserved_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd13) |=> $stable(count));

  // R11: no waveform in non-PWM modes
  p_pwm_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd0 || mode == 4'd4 || mode == 4'd12 || mode == 4'd13) |=> !pwmOut);

endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tick;
  logic [3:0]  mode;
  logic        wrCmpA, wrCmpB, wrCapt;
  logic [15:0] wrData;
  logic [2:0]  flagClr;
  logic [15:0] count;
  logic        pwmOut, ovfFlag, cmpAFlag, cmpBFlag;

  int checks = 0;
  int failures = 0;
  bit gated = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  pwm_timer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode),
    .wrCmpA(wrCmpA), .wrCmpB(wrCmpB), .wrCapt(wrCapt), .wrData(wrData),
    .flagClr(flagClr), .count(count), .pwmOut(pwmOut),
    .ovfFlag(ovfFlag), .cmpAFlag(cmpAFlag), .cmpBFlag(cmpBFlag)
  );

  typedef struct {
    logic [15:0] cnt;
    logic        ovf, fa, fb, pwm;
    logic [3:0]  md;
  } exp_t;
  exp_t q[$];

  // Reference model state
  logic [15:0] mCnt, mBufA, mBufB, mActA, mActB, mCap;
  bit mUp, mOvf, mFa, mFb, mPwm;

  // Mode table: tk 0 full,1 8b,2 9b,3 10b,4 cmpA,5 capt; ld 0 now,1 top,2 bottom;
  // ov 0 max,1 top,2 bottom; wv 0 none,1 fast,2 dual
  task automatic decode(input logic [3:0] m, output int tk, output bit du,
                        output int ld, output int ov, output int wv);
    case (m)
      4'd0:  begin tk=0; du=0; ld=0; ov=0; wv=0; end
      4'd1:  begin tk=1; du=1; ld=1; ov=2; wv=2; end
      4'd2:  begin tk=2; du=1; ld=1; ov=2; wv=2; end
      4'd3:  begin tk=3; du=1; ld=1; ov=2; wv=2; end
      4'd4:  begin tk=4; du=0; ld=0; ov=0; wv=0; end
      4'd5:  begin tk=1; du=0; ld=2; ov=1; wv=1; end
      4'd6:  begin tk=2; du=0; ld=2; ov=1; wv=1; end
      4'd7:  begin tk=3; du=0; ld=2; ov=1; wv=1; end
      4'd8:  begin tk=5; du=1; ld=2; ov=2; wv=2; end
      4'd9:  begin tk=4; du=1; ld=2; ov=2; wv=2; end
      4'd10: begin tk=5; du=1; ld=1; ov=2; wv=2; end
      4'd11: begin tk=4; du=1; ld=1; ov=2; wv=2; end
      4'd12: begin tk=5; du=0; ld=0; ov=0; wv=0; end
      4'd13: begin tk=0; du=0; ld=0; ov=0; wv=0; end
      4'd14: begin tk=5; du=0; ld=2; ov=1; wv=1; end
      default: begin tk=4; du=0; ld=2; ov=1; wv=1; end
    endcase
  endtask

  task automatic modelStep();
    int tk, ld, ov, wv;
    bit du, run, aTop, aZero, aMax, pTop, fa, fb, ldEv, ovEv, nUp, nPwm;
    logic [15:0] topv, nCnt;
    decode(mode, tk, du, ld, ov, wv);
    case (tk)
      0: topv = 16'hFFFF;
      1: topv = 16'h00FF;
      2: topv = 16'h01FF;
      3: topv = 16'h03FF;
      4: topv = mActA;
      default: topv = mCap;
    endcase
    run   = tick && (mode != 4'd13);
    aTop  = (mCnt == topv);
    aZero = (mCnt == 16'h0);
    aMax  = (mCnt == 16'hFFFF);
    pTop  = (mCnt >= topv);
    nCnt = mCnt; nUp = mUp; nPwm = mPwm;
    if (run) begin
      if (!du) nCnt = aTop ? 16'h0 : mCnt + 16'h1;
      else if (mUp) begin
        if (pTop) begin nUp = 0; nCnt = aZero ? mCnt : mCnt - 16'h1; end
        else nCnt = mCnt + 16'h1;
      end else begin
        if (aZero) begin nUp = 1; nCnt = aTop ? mCnt : mCnt + 16'h1; end
        else nCnt = mCnt - 16'h1;
      end
    end
    fa   = run && (mCnt == mActA);
    fb   = run && (mCnt == mActB);
    ldEv = run && ((ld == 1 && aTop) || (ld == 2 && aZero));
    ovEv = run && ((ov == 0 && aMax) || (ov == 1 && aTop) || (ov == 2 && aZero));
    if (wv == 0) nPwm = 0;
    else if (wv == 1) begin
      if (fb) nPwm = 0;
      else if (run && aTop) nPwm = 1;
    end else if (fb) nPwm = !mUp;
    mOvf = ovEv || (mOvf && !flagClr[0]);
    mFa  = fa || (mFa && !flagClr[1]);
    mFb  = fb || (mFb && !flagClr[2]);
    if (ldEv) begin mActA = mBufA; mActB = mBufB; end
    if (wrCmpA) begin mBufA = wrData; if (ld == 0) mActA = wrData; end
    if (wrCmpB) begin mBufB = wrData; if (ld == 0) mActB = wrData; end
    if (wrCapt) mCap = wrData;
    mCnt = nCnt; mUp = nUp; mPwm = nPwm;
  endtask

  // Driver side of the scoreboard: model advances and pushes the expected item
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mBufA = 0; mBufB = 0; mActA = 0; mActB = 0; mCap = 0;
      mUp = 1; mOvf = 0; mFa = 0; mFb = 0; mPwm = 0;
    end else modelStep();
    q.push_back('{cnt: mCnt, ovf: mOvf, fa: mFa, fb: mFb, pwm: mPwm, md: mode});
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      int tk, ld, ov, wv;
      bit du;
      string cTag, pTag;
      e = q.pop_front();
      decode(e.md, tk, du, ld, ov, wv);
      cTag = (e.md == 4'd13) ? "R11" : (du ? "R3" : "R2");
      pTag = (wv == 1) ? "R9" : ((wv == 2) ? "R10" : "R11");
      check(count == e.cnt, cTag, "count", count, e.cnt);
      check(ovfFlag == e.ovf, "R6", "ovfFlag", ovfFlag, e.ovf);
      check(cmpAFlag == e.fa, "R7", "cmpAFlag", cmpAFlag, e.fa);
      check(cmpBFlag == e.fb, "R7", "cmpBFlag", cmpBFlag, e.fb);
      check(pwmOut == e.pwm, pTag, "pwmOut", pwmOut, e.pwm);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; tick = 0; flagClr = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic wr(input int which, input logic [15:0] v);
    wrData = v;
    wrCmpA = (which == 0);
    wrCmpB = (which == 1);
    wrCapt = (which == 2);
    @(negedge clk);
    wrCmpA = 0; wrCmpB = 0; wrCapt = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick = gated ? lfsr[0] : 1'b1;
      @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic scenario(input logic [3:0] m, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] c, input int n);
    doReset();
    mode = m;
    wr(0, a); wr(1, b); wr(2, c);
    run(n / 2);
    wr(1, b + 16'd3);
    run(n / 2);
  endtask

  initial begin
    rstN = 0; tick = 0; mode = 0; wrCmpA = 0; wrCmpB = 0; wrCapt = 0;
    wrData = 0; flagClr = 0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(count == 0, "R1", "count", count, 0);
    check(ovfFlag == 0 && cmpAFlag == 0 && cmpBFlag == 0, "R1", "flags",
          {ovfFlag, cmpAFlag, cmpBFlag}, 0);
    check(pwmOut == 0, "R1", "pwmOut", pwmOut, 0);
    rstN = 1;

    // R4: clear-on-match with TOP from compare A = 9
    doReset(); mode = 4'd4;
    wr(0, 16'd9);
    tick = 1; repeat (9) @(negedge clk);
    check(count == 16'd9, "R4", "count at TOP", count, 9);
    @(negedge clk);
    check(count == 16'd0, "R4", "count after wrap", count, 0);
    tick = 0;

    // R5: buffered TOP in mode 15 loads only at bottom
    doReset(); mode = 4'd15;
    wr(0, 16'd20);
    tick = 1; @(negedge clk);
    check(count == 16'd0, "R5", "count with old TOP", count, 0);
    repeat (3) @(negedge clk);
    tick = 0;
    wr(0, 16'd5);
    tick = 1; repeat (17) @(negedge clk);
    check(count == 16'd20, "R5", "count reaches old TOP", count, 20);
    @(negedge clk);
    check(count == 16'd0, "R5", "wrap at old TOP", count, 0);
    repeat (6) @(negedge clk);
    check(count == 16'd0, "R5", "wrap at new TOP", count, 0);
    tick = 0;

    // R7 and R8: flag set and write-one-to-clear
    doReset(); mode = 4'd4;
    wr(0, 16'd3);
    tick = 1; repeat (4) @(negedge clk); tick = 0;
    check(cmpAFlag == 1, "R7", "cmpAFlag set", cmpAFlag, 1);
    flagClr = 3'b010; @(negedge clk); flagClr = 0;
    check(cmpAFlag == 0, "R8", "cmpAFlag cleared", cmpAFlag, 0);
    check(cmpBFlag == 1, "R8", "cmpBFlag kept", cmpBFlag, 1);

    // R11: reserved mode holds
    doReset(); mode = 4'd13;
    run(12);
    check(count == 0, "R11", "reserved count", count, 0);

    // Scoreboarded runs across the mode table (R2, R3, R4, R5, R6, R9, R10)
    scenario(4'd5,  16'd0,  16'h40, 16'd0,  600);
    scenario(4'd6,  16'd0,  16'h100, 16'd0, 1100);
    scenario(4'd7,  16'd0,  16'h200, 16'd0, 2100);
    scenario(4'd1,  16'd0,  16'h80, 16'd0,  1100);
    scenario(4'd2,  16'd0,  16'h90, 16'd0,  2100);
    scenario(4'd3,  16'd0,  16'h100, 16'd0, 4200);
    scenario(4'd12, 16'd2,  16'd4,  16'd11, 60);
    scenario(4'd14, 16'd2,  16'd7,  16'd20, 120);
    scenario(4'd15, 16'd30, 16'd10, 16'd0,  200);
    scenario(4'd8,  16'd3,  16'd5,  16'd25, 240);
    scenario(4'd9,  16'd17, 16'd6,  16'd0,  200);
    scenario(4'd10, 16'd4,  16'd8,  16'd12, 160);
    scenario(4'd11, 16'd14, 16'd2,  16'd0,  160);
    gated = 1;
    scenario(4'd9,  16'd21, 16'd9,  16'd0,  300);
    scenario(4'd14, 16'd1,  16'd5,  16'd13, 300);
    gated = 0;
    // R6: overflow at MAX in normal mode
    scenario(4'd0, 16'd100, 16'd200, 16'd0, 65545);
    check(ovfFlag == 1, "R6", "ovfFlag after MAX", ovfFlag, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule